// File: doc/BRIEF.md
# DMA Completion Interrupt Bank

This block gathers the completion events of up to sixteen DMA channels into one interrupt line. Each channel owns a 4-bit field. Eight fields fill one 32-bit word, so two words cover sixteen channels. Within a field, bit 1 is the package-complete flag. The other three positions are reserved: they read as zero and ignore writes.

Each word exists as an enable register and as a pending register. A completion pulse latches its pending bit whether or not the channel is enabled. The interrupt output is high while any channel has both its pending bit and its enable bit set. Software clears pending bits by writing ones. Software can silence the whole bank by writing zero to both enable words.

The register port has a write strobe and a read path. Reads are combinational from the address. The channel count is a parameter. Channels above that count have no storage and read as zero.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset all enable and pending bits are 0, every register reads 0 and `irq` is low.
- R2: Writing offset 0x00 loads the enables of channels 0..7 and writing offset 0x04 loads those of channels 8..15. Channel c uses bit (c mod 8)*4+1 of its word. A read returns the stored value.
- R3: A high level on `chan_evt[4c+1]` at a rising clock edge sets the pending bit of channel c, whatever its enable. That bit is bit (c mod 8)*4+1 of offset 0x10 for channels 0..7, and of offset 0x14 for channels 8..15.
- R4: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Without a write to its word, a pending bit stays set.
- R5: When an event and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly while some channel has both its pending and enable bits set. It follows the registers with no added delay.
- R7: Field bits 0, 2 and 3 (the other three event kinds on `chan_evt[4c+0/2/3]`) are never stored. They read as 0 in every register.
- R8: Channels numbered NUM_CH or higher have enable and pending bits that always read 0.
- R9: With NUM_CH of 8 or fewer, offsets 0x04 and 0x14 read 0 whatever is written.
- R10: Addresses other than the four register offsets read 0, and writes to them change no register.
- R11: Writing 0 to both enable words forces `irq` low while the pending bits are kept. Writing all ones to both pending words clears every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| chan_evt | input | 4*NUM_CH | Per-channel event pulses, four kinds per channel; kind 1 is package complete |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies side by side, sharing the register bus. One has NUM_CH = 12, so its second word is only half populated. The other has NUM_CH = 8, so its second word pair is absent. The 12-channel copy shows the boundary between implemented and missing channel fields inside one word, using enable and pending readback. The 8-channel copy shows that the upper offsets read zero even under writes and events. Directed scenarios cover event latching while the channel is disabled, clearing by writing ones, a clear colliding with an event, reserved event kinds, and global masking and clearing.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int MAX_CH      = 16;
  localparam int CH_PER_WORD = 8;
  localparam int FIELD_W     = 4;
  localparam int PKG_BIT     = 1;
  localparam int WORD_W      = CH_PER_WORD * FIELD_W;
  localparam int NUM_WORDS   = MAX_CH / CH_PER_WORD;
  localparam int OFS_EN_BASE = 'h00;
  localparam int OFS_PD_BASE = 'h10;
  localparam int WORD_STRIDE = 4;

  function automatic logic [CH_PER_WORD-1:0] pick_lanes(input logic [WORD_W-1:0] w);
    logic [CH_PER_WORD-1:0] r;
    for (int k = 0; k < CH_PER_WORD; k++) r[k] = w[k*FIELD_W + PKG_BIT];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] spread_lanes(input logic [CH_PER_WORD-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int k = 0; k < CH_PER_WORD; k++) r[k*FIELD_W + PKG_BIT] = v[k];
    return r;
  endfunction

  function automatic logic [CH_PER_WORD-1:0] live_mask(input int n);
    logic [CH_PER_WORD-1:0] r;
    for (int k = 0; k < CH_PER_WORD; k++) r[k] = (k < n);
    return r;
  endfunction

  localparam logic [WORD_W-1:0] LANE_MASK = spread_lanes({CH_PER_WORD{1'b1}});
endpackage

// File: rtl/dma_irq_slice.sv
module dma_irq_slice
  import dma_irq_pkg::*;
#(
  parameter int CH_CNT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_we,
  input  logic                   pend_we,
  input  logic [CH_PER_WORD-1:0] lanes,
  input  logic [CH_PER_WORD-1:0] evt,
  output logic [CH_PER_WORD-1:0] en_o,
  output logic [CH_PER_WORD-1:0] pend_o
);
  localparam logic [CH_PER_WORD-1:0] LIVE = live_mask(CH_CNT);

  logic [CH_PER_WORD-1:0] en_d, en_q, pend_d, pend_q;
  logic                   pend_ce;

  always_comb begin
    en_d    = lanes & LIVE;
    pend_d  = pend_q;
    if (pend_we) pend_d = pend_q & ~lanes;
    pend_d  = (pend_d | evt) & LIVE;
    pend_ce = pend_we | (|(evt & LIVE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (pend_ce) pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & LIVE)) |=> ((pend_q & $past(evt & LIVE)) == $past(evt & LIVE))); // R3
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> ((pend_q & $past(lanes & ~evt)) == '0)); // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_we |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q)); // R2
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAX_CH-1:0] en_all,
  input  logic [MAX_CH-1:0] pend_all,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(OFS_EN_BASE + w*WORD_STRIDE))
        rd_data = spread_lanes(en_all[w*CH_PER_WORD +: CH_PER_WORD]);
      if (addr == ADDR_W'(OFS_PD_BASE + w*WORD_STRIDE))
        rd_data = spread_lanes(pend_all[w*CH_PER_WORD +: CH_PER_WORD]);
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [WORD_W-1:0]         rd_data,
  input  logic [FIELD_W*NUM_CH-1:0] chan_evt,
  output logic                      irq
);
  logic [MAX_CH-1:0]      evt_pkg, en_all, pend_all;
  logic [CH_PER_WORD-1:0] lanes;
  logic [NUM_WORDS-1:0]   en_we_v, pend_we_v;

  always_comb begin
    evt_pkg = '0;
    for (int c = 0; c < NUM_CH; c++) evt_pkg[c] = chan_evt[c*FIELD_W + PKG_BIT];
  end

  assign lanes = pick_lanes(wr_data);

  for (genvar s = 0; s < NUM_WORDS; s++) begin : g_word
    localparam int CNT = (NUM_CH >= (s+1)*CH_PER_WORD) ? CH_PER_WORD :
                         (NUM_CH > s*CH_PER_WORD) ? NUM_CH - s*CH_PER_WORD : 0;
    assign en_we_v[s]   = wr_en && (addr == ADDR_W'(OFS_EN_BASE + s*WORD_STRIDE));
    assign pend_we_v[s] = wr_en && (addr == ADDR_W'(OFS_PD_BASE + s*WORD_STRIDE));
    dma_irq_slice #(.CH_CNT(CNT)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_we   (en_we_v[s]),
      .pend_we (pend_we_v[s]),
      .lanes   (lanes),
      .evt     (evt_pkg[s*CH_PER_WORD +: CH_PER_WORD]),
      .en_o    (en_all[s*CH_PER_WORD +: CH_PER_WORD]),
      .pend_o  (pend_all[s*CH_PER_WORD +: CH_PER_WORD])
    );
  end

  dma_irq_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr     (addr),
    .en_all   (en_all),
    .pend_all (pend_all),
    .rd_data  (rd_data)
  );

  assign irq = |(en_all & pend_all);

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_all)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq); // R11
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LANE_MASK) == '0); // R7

  if (NUM_CH <= CH_PER_WORD) begin : g_narrow
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr == ADDR_W'(OFS_EN_BASE + WORD_STRIDE)) ||
       (addr == ADDR_W'(OFS_PD_BASE + WORD_STRIDE))) |-> (rd_data == '0)); // R9
  end
endmodule

// File: tb/dma_irq_bank_tb_top.sv
module dma_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [47:0] evt_a = '0;
  logic [31:0] evt_b = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_irq_bank #(.NUM_CH(12), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_a), .chan_evt(evt_a), .irq(irq_a));

  dma_irq_bank #(.NUM_CH(8), .ADDR_W(8)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_b), .chan_evt(evt_b), .irq(irq_b));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a,
                        input logic [31:0] exp_a, input logic [31:0] exp_b);
    addr = a;
    #1;
    chk(req, rd_a, exp_a);
    chk(req, rd_b, exp_b);
  endtask

  task automatic pulse(input logic [47:0] ea, input logic [31:0] eb);
    @(negedge clk);
    evt_a = ea; evt_b = eb;
    @(negedge clk);
    evt_a = '0; evt_b = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1", 8'h00, 0, 0);
    rd_chk("R1", 8'h04, 0, 0);
    rd_chk("R1", 8'h10, 0, 0);
    rd_chk("R1", 8'h14, 0, 0);
    chk("R1", {31'b0, irq_a | irq_b}, 0);
  endtask

  task automatic t_enable_map;
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h00, 32'h2222_2222, 32'h2222_2222);
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R8", 8'h04, 32'h0000_2222, 32'h0);
    wr(8'h00, 32'h0000_0020);
    rd_chk("R2", 8'h00, 32'h0000_0020, 32'h0000_0020);
    wr(8'h00, 0);
    wr(8'h04, 0);
    rd_chk("R2", 8'h04, 0, 0);
  endtask

  task automatic t_event_latch;
    pulse(48'h0000_0000_2000 | (48'h1 << 37), 32'h0000_2000);
    rd_chk("R3", 8'h10, 32'h0000_2000, 32'h0000_2000);
    rd_chk("R3", 8'h14, 32'h0000_0020, 32'h0);
    chk("R6", {31'b0, irq_a}, 0);
    wr(8'h00, 32'h0000_2000);
    chk("R6", {31'b0, irq_a}, 1);
    chk("R6", {31'b0, irq_b}, 1);
    wr(8'h00, 32'h0000_0200);
    chk("R6", {31'b0, irq_a}, 0);
    wr(8'h00, 0);
  endtask

  task automatic t_other_kinds;
    pulse(48'h0000_00D0_0000, 32'h00D0_0000);
    rd_chk("R7", 8'h10, 32'h0000_2000, 32'h0000_2000);
  endtask

  task automatic t_clear;
    wr(8'h10, 32'h0);
    rd_chk("R4", 8'h10, 32'h0000_2000, 32'h0000_2000);
    wr(8'h10, 32'h0000_2000);
    rd_chk("R4", 8'h10, 0, 0);
    rd_chk("R4", 8'h14, 32'h0000_0020, 0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R11", 8'h14, 0, 0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    evt_a = 48'h200; evt_b = 32'h200;
    wr_en = 1'b1; addr = 8'h10; wr_data = 32'h0000_0200;
    @(negedge clk);
    evt_a = '0; evt_b = '0; wr_en = 1'b0;
    rd_chk("R5", 8'h10, 32'h0000_0200, 32'h0000_0200);
    wr(8'h10, 32'h0000_0200);
    rd_chk("R5", 8'h10, 0, 0);
  endtask

  task automatic t_global;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    pulse(48'h2222_2222_2222, 32'h2222_2222);
    rd_chk("R3", 8'h10, 32'h2222_2222, 32'h2222_2222);
    rd_chk("R9", 8'h14, 32'h0000_2222, 32'h0);
    chk("R6", {30'b0, irq_a, irq_b}, 2'b11);
    wr(8'h00, 0);
    wr(8'h04, 0);
    chk("R11", {30'b0, irq_a, irq_b}, 2'b00);
    rd_chk("R11", 8'h10, 32'h2222_2222, 32'h2222_2222);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R11", 8'h10, 0, 0);
    rd_chk("R11", 8'h14, 0, 0);
  endtask

  task automatic t_unmapped;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk("R10", 8'h08, 0, 0);
    rd_chk("R10", 8'h30, 0, 0);
    rd_chk("R10", 8'h00, 0, 0);
    rd_chk("R10", 8'h04, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_map();
    t_event_latch();
    t_other_kinds();
    t_clear();
    t_collide();
    t_global();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule